// File: doc/BRIEF.md
# Synthesizer I2C register interface

This block is an I2C slave that holds the programming of a PLL tuning synthesizer and reports its status. SCL and SDA are oversampled on the system clock, and the block pulls SDA low through an open-drain enable. The block answers to a 7-bit address whose two low bits come from a select input. It also answers to a fixed general address, whatever the select input says.

A write transfer carries data bytes with auto-increment. The most significant bit of a byte in the selecting position chooses its meaning. A 0 starts a two-byte frequency word, and a 1 marks a control byte, which is always followed by a ports byte. Each register commits only when the last byte that feeds it completes. An unfinished byte, or a frequency word that never gets its second byte, changes nothing.

A read transfer returns a status byte. It carries a power-on flag, the loop lock input and a 3-bit converter code that is supplied from outside the block.

Top module: `synth_i2c_regs`

## Requirements
- R1: After reset the divider is 0, the charge-pump select is 0, the test field is 3'b001, the ratio select is 2'b00, the tuning disable is 0, all open-collector and band outputs are 0, and SDA is released.
- R2: An address byte is acknowledged by pulling SDA low on the 9th SCL clock exactly when its upper 7 bits equal {5'b11000, addr_sel_i} or the general value 7'h61 (byte C2h for write, C3h for read).
- R3: An address byte that does not match gets no acknowledge, and the data bytes that follow leave every register unchanged.
- R4: A selecting byte with bit 7 = 0 stages its bits 6..0 as divider bits 14..8. The next byte supplies bits 7..0, and div_o takes the 15-bit value once the 8th clock of that second byte has been received.
- R5: A first frequency byte that is followed by a stop instead of its partner leaves div_o unchanged.
- R6: A selecting byte with bit 7 = 1 is a control byte. Bit 6 goes to cp_hi_o, bits 5..3 to test_o, bits 2..1 to ref_sel_o and bit 0 to tune_off_o, all committed at its 8th clock.
- R7: The byte after a control byte is a ports byte. Bits 7..4 go to oc_o[3:0] and bits 2..0 go to bs_o, while bit 3 has no effect.
- R8: Once a frequency pair or a ports byte completes, the next byte is again a selecting byte. This lets one transfer carry the sequence frequency, frequency, control, ports, or any chain of such groups.
- R9: A read returns the status byte MSB first: bit 7 power-on flag, bit 6 lock_i, bits 5..3 zero, bits 2..0 adc_code_i. If the master acknowledges, the status byte is sent again.
- R10: The power-on flag is 1 from reset and clears when the master clocks the 9th bit of the first read byte. Every later status byte shows it as 0.
- R11: A stop or a repeated start in the middle of a byte discards that byte, and no register takes any of its bits.
- R12: The SDA enable changes only while SCL is low, apart from releases at a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 2 | Low two address bits |
| lock_i | input | 1 | Loop lock indication |
| adc_code_i | input | 3 | Converter code for the status byte |
| div_o | output | 15 | Programmable divider ratio |
| cp_hi_o | output | 1 | Charge-pump high current select |
| test_o | output | 3 | Test mode field |
| ref_sel_o | output | 2 | Reference divider ratio select |
| tune_off_o | output | 1 | Tuning output disable |
| oc_o | output | 4 | Open-collector port controls |
| bs_o | output | 3 | Band switch buffer controls |

## Verification
Both bus lines pass through two synchronizer flops and one edge register. A received bit therefore becomes an event about 3 clocks after the raw SCL rise. A register commits 2 clocks after that event, and the SDA enable moves about 3 clocks after a raw SCL fall. The bench holds each SCL phase for at least 4 clocks. It reads acknowledges and read data one quarter-bit after SCL rises, and it reads register outputs only after the acknowledge clock or after the stop has finished. None of these results is looked at inside its settling window. A monitor flags any SDA-enable change while SCL is high.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
  typedef enum logic [2:0] {
    EN_IDLE, EN_ADDR, EN_WR, EN_ACK, EN_RD, EN_MACK
  } eng_state_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SEL, PH_DB2, PH_PB
  } wr_phase_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/synth_i2c_sync.sv
module synth_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_s, sda_s, scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_s      = sda_q[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA edge while SCL stays high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/synth_i2c_engine.sv
module synth_i2c_engine
  import synth_i2c_pkg::*;
#(
  parameter int          SEL_W     = 2,
  parameter logic [4:0]  ADDR_BASE = 5'b11000,
  parameter bit          GEN_EN    = 1'b1,
  parameter logic [6:0]  GEN_ADDR  = 7'h61
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic              addr_wr_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_done_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  eng_state_e        state;
  logic [BYTE_W-1:0] shreg, tx;
  logic [CNT_W-1:0]  bcnt;
  logic              ack_pend, rd_mode, more;
  logic              own_hit, gen_hit, hit;

  assign own_hit = (shreg[6:0] == {ADDR_BASE, addr_sel_i});

  generate
    if (GEN_EN) begin : g_gen
      assign gen_hit = (shreg[6:0] == GEN_ADDR);
    end else begin : g_nogen
      assign gen_hit = 1'b0;
    end
  endgenerate

  assign hit = own_hit | gen_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= EN_IDLE;
      shreg      <= '0;
      tx         <= '0;
      bcnt       <= '0;
      ack_pend   <= 1'b0;
      rd_mode    <= 1'b0;
      more       <= 1'b0;
      sda_oe_o   <= 1'b0;
      addr_wr_o  <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      rd_done_o  <= 1'b0;
    end else begin
      addr_wr_o  <= 1'b0;
      wr_valid_o <= 1'b0;
      rd_done_o  <= 1'b0;
      if (start_i) begin
        state    <= EN_ADDR;
        bcnt     <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= EN_IDLE;
        sda_oe_o <= 1'b0;
      end else if (scl_rise_i) begin
        case (state)
          EN_ADDR, EN_WR: begin
            shreg <= {shreg[BYTE_W-2:0], sda_i};
            bcnt  <= bcnt + 1'b1;
            if (bcnt == LAST_BIT) begin
              if (state == EN_ADDR) begin
                ack_pend  <= hit;
                rd_mode   <= sda_i;
                addr_wr_o <= hit & ~sda_i;
              end else begin
                ack_pend   <= 1'b1;
                wr_valid_o <= 1'b1;
                wr_data_o  <= {shreg[BYTE_W-2:0], sda_i};
              end
            end
          end
          EN_RD:   bcnt <= bcnt + 1'b1;
          EN_MACK: begin
            rd_done_o <= 1'b1;
            more      <= ~sda_i;
          end
          default: ;
        endcase
      end else if (scl_fall_i) begin
        case (state)
          EN_ADDR, EN_WR: begin
            if (bcnt == FULL) begin
              if (ack_pend) begin
                sda_oe_o <= 1'b1;
                state    <= EN_ACK;
              end else begin
                state <= EN_IDLE;
              end
            end
          end
          EN_ACK: begin
            bcnt <= '0;
            if (rd_mode) begin
              tx       <= {status_i[BYTE_W-2:0], 1'b0};
              sda_oe_o <= ~status_i[BYTE_W-1];
              state    <= EN_RD;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= EN_WR;
            end
          end
          EN_RD: begin
            if (bcnt == FULL) begin
              sda_oe_o <= 1'b0;
              state    <= EN_MACK;
            end else begin
              sda_oe_o <= ~tx[BYTE_W-1];
              tx       <= {tx[BYTE_W-2:0], 1'b0};
            end
          end
          EN_MACK: begin
            if (more) begin
              bcnt     <= '0;
              tx       <= {status_i[BYTE_W-2:0], 1'b0};
              sda_oe_o <= ~status_i[BYTE_W-1];
              state    <= EN_RD;
            end else begin
              state <= EN_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_i2c_bank.sv
module synth_i2c_bank
  import synth_i2c_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_wr_i,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_done_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              cp_hi_o,
  output logic [2:0]        test_o,
  output logic [1:0]        ref_sel_o,
  output logic              tune_off_o,
  output logic [3:0]        oc_o,
  output logic [2:0]        bs_o,
  output logic              por_o
);
  localparam int HI_W = DIV_W - BYTE_W;

  wr_phase_e       phase;
  logic [HI_W-1:0] hi_q;
  logic            unused_pb_bit;

  assign unused_pb_bit = wr_data_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase      <= PH_IDLE;
      hi_q       <= '0;
      div_o      <= '0;
      cp_hi_o    <= 1'b0;
      test_o     <= 3'b001;
      ref_sel_o  <= 2'b00;
      tune_off_o <= 1'b0;
      oc_o       <= '0;
      bs_o       <= '0;
      por_o      <= 1'b1;
    end else begin
      if (rd_done_i) por_o <= 1'b0;
      if (start_i || stop_i) begin
        phase <= PH_IDLE;
      end else if (addr_wr_i) begin
        phase <= PH_SEL;
      end else if (wr_valid_i) begin
        case (phase)
          PH_SEL: begin
            if (!wr_data_i[BYTE_W-1]) begin
              hi_q  <= wr_data_i[HI_W-1:0];
              phase <= PH_DB2;
            end else begin
              cp_hi_o    <= wr_data_i[6];
              test_o     <= wr_data_i[5:3];
              ref_sel_o  <= wr_data_i[2:1];
              tune_off_o <= wr_data_i[0];
              phase      <= PH_PB;
            end
          end
          PH_DB2: begin
            div_o <= {hi_q, wr_data_i};
            phase <= PH_SEL;
          end
          PH_PB: begin
            oc_o  <= wr_data_i[7:4];
            bs_o  <= wr_data_i[2:0];
            phase <= PH_SEL;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_i2c_regs.sv
module synth_i2c_regs
  import synth_i2c_pkg::*;
#(
  parameter int         DIV_W       = 15,
  parameter int         SEL_W       = 2,
  parameter int         ADC_W       = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_BASE   = 5'b11000,
  parameter logic [6:0] GEN_ADDR    = 7'h61
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [SEL_W-1:0] addr_sel_i,
  input  logic             lock_i,
  input  logic [ADC_W-1:0] adc_code_i,
  output logic [DIV_W-1:0] div_o,
  output logic             cp_hi_o,
  output logic [2:0]       test_o,
  output logic [1:0]       ref_sel_o,
  output logic             tune_off_o,
  output logic [3:0]       oc_o,
  output logic [2:0]       bs_o
);
  localparam int PAD_W = BYTE_W - 2 - ADC_W;

  logic              sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic              addr_wr, wr_valid, rd_done, por;
  logic [BYTE_W-1:0] wr_data, status;

  assign status = {por, lock_i, {PAD_W{1'b0}}, adc_code_i};

  synth_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  synth_i2c_engine #(
    .SEL_W     (SEL_W),
    .ADDR_BASE (ADDR_BASE),
    .GEN_EN    (1'b1),
    .GEN_ADDR  (GEN_ADDR)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .addr_sel_i (addr_sel_i),
    .status_i   (status),
    .sda_oe_o   (sda_oe_o),
    .addr_wr_o  (addr_wr),
    .wr_valid_o (wr_valid),
    .wr_data_o  (wr_data),
    .rd_done_o  (rd_done)
  );

  synth_i2c_bank #(.DIV_W(DIV_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .addr_wr_i  (addr_wr),
    .wr_valid_i (wr_valid),
    .wr_data_i  (wr_data),
    .rd_done_i  (rd_done),
    .div_o      (div_o),
    .cp_hi_o    (cp_hi_o),
    .test_o     (test_o),
    .ref_sel_o  (ref_sel_o),
    .tune_off_o (tune_off_o),
    .oc_o       (oc_o),
    .bs_o       (bs_o),
    .por_o      (por)
  );
endmodule

// File: rtl/synth_i2c_chk.sv
module synth_i2c_chk #(
  parameter int DIV_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_oe_o,
  input logic             scl_fall,
  input logic             start_p,
  input logic             stop_p,
  input logic             wr_valid,
  input logic             rd_done,
  input logic             por,
  input logic [DIV_W-1:0] div_o,
  input logic [6:0]       ctrl_v,
  input logic [6:0]       port_v
);
  // R4
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid |=> $stable(div_o));

  // R6
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid |=> $stable(ctrl_v));

  // R7
  port_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid |=> $stable(port_v));

  // R10
  por_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_done |=> !$fell(por));

  // R12
  sda_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> ($past(scl_fall) || $past(start_p) || $past(stop_p)));

  // R9
  mack_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done |-> !sda_oe_o);
endmodule

bind synth_i2c_regs synth_i2c_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sda_oe_o (sda_oe_o),
  .scl_fall (scl_fall),
  .start_p  (start_p),
  .stop_p   (stop_p),
  .wr_valid (wr_valid),
  .rd_done  (rd_done),
  .por      (por),
  .div_o    (div_o),
  .ctrl_v   ({cp_hi_o, test_o, ref_sel_o, tune_off_o}),
  .port_v   ({oc_o, bs_o})
);

// File: tb/tb_synth_i2c_regs.sv
module tb_synth_i2c_regs;
  localparam int Q = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0]  addr_sel = 2'd0;
  logic        lock = 1'b0;
  logic [2:0]  adc = 3'd0;
  logic        sda_oe;
  logic [14:0] div;
  logic        cp_hi, tune_off;
  logic [2:0]  test, bs;
  logic [1:0]  ref_sel;
  logic [3:0]  oc;
  wire         sda_line = sda_m & ~sda_oe;

  int n_cmp = 0, n_bad = 0, viol = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  always #10 clk = ~clk;

  synth_i2c_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .lock_i(lock),
    .adc_code_i(adc), .div_o(div), .cp_hi_o(cp_hi), .test_o(test),
    .ref_sel_o(ref_sel), .tune_off_o(tune_off), .oc_o(oc), .bs_o(bs)
  );

  // R12 monitor: SDA enable must not move while SCL is high
  always @(posedge clk) begin
    prev_oe  <= sda_oe;
    prev_scl <= scl_m;
    if (rst_ni && scl_m && prev_scl && (sda_oe !== prev_oe)) viol++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) put_bit(b[7 - i]);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      d = {d[6:0], sda_line}; tick(Q); scl_m = 1'b0; tick(Q);
    end
    put_bit(~mack);
  endtask

  function automatic logic [7:0] cb(input logic c, input logic [2:0] t,
                                    input logic [1:0] r, input logic o);
    return {1'b1, c, t, r, o};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    tick(5); rst_ni = 1'b1; tick(5);

    // R1 reset state
    check("R1 div", 32'(div), 0);
    check("R1 cp", 32'(cp_hi), 0);
    check("R1 test", 32'(test), 1);
    check("R1 ref", 32'(ref_sel), 0);
    check("R1 os", 32'(tune_off), 0);
    check("R1 ports", 32'({oc, bs}), 0);
    check("R1 sda", 32'(sda_oe), 0);

    // R2 address sweep over three select values
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      addr_sel = 2'(s);
      for (int a = 0; a < 128; a++) begin
        logic exp_ack;
        exp_ack = (7'(a) == {5'b11000, 2'(s)}) || (7'(a) == 7'h61);
        bus_start();
        put_byte({7'(a), 1'b0}, ack);
        bus_stop();
        check("R2 ack", 32'(ack), 32'(exp_ack));
      end
    end

    // R3 mismatched writes change nothing
    addr_sel = 2'd0;
    for (int k = 0; k < 3; k++) begin
      bus_start();
      put_byte({7'h64 + 7'(k), 1'b0}, ack);
      check("R3 nack", 32'(ack), 0);
      put_byte(8'h15, ack);
      put_byte(8'hA5, ack);
      put_byte(cb(1'b1, 3'd6, 2'd3, 1'b1), ack);
      bus_stop();
      check("R3 div", 32'(div), 0);
      check("R3 ctrl", 32'({cp_hi, test, ref_sel, tune_off}), 32'({1'b0, 3'd1, 2'd0, 1'b0}));
    end

    // R4 R6 R7 R8 full programming in one transfer
    addr_sel = 2'd2;
    for (int i = 0; i < 6; i++) begin
      logic [14:0] n;
      logic [2:0]  t, b;
      logic [1:0]  r;
      logic [3:0]  o;
      logic [14:0] old;
      n = 15'((i * 15'h1357) ^ 15'h2AAA ^ (i * i));
      t = 3'(i * 3 + 1); r = 2'(i); b = 3'(7 - i); o = 4'(i * 5 + 3);
      old = div;
      bus_start();
      put_byte({7'h62, 1'b0}, ack);
      check("R2 own ack", 32'(ack), 1);
      put_byte({1'b0, n[14:8]}, ack);
      check("R5 db1 alone", 32'(div), 32'(old));
      put_byte(n[7:0], ack);
      check("R4 div", 32'(div), 32'(n));
      put_byte(cb(i[0], t, r, i[1]), ack);
      check("R6 ctrl", 32'({cp_hi, test, ref_sel, tune_off}), 32'({i[0], t, r, i[1]}));
      put_byte({o, i[0], b}, ack);
      bus_stop();
      check("R7 oc", 32'(oc), 32'(o));
      check("R7 bs", 32'(bs), 32'(b));
      check("R8 div kept", 32'(div), 32'(n));
    end

    // R8 two frequency pairs back to back
    bus_start();
    put_byte({7'h62, 1'b0}, ack);
    put_byte(8'h12, ack); put_byte(8'h34, ack);
    put_byte(8'h56, ack); put_byte(8'h78, ack);
    bus_stop();
    check("R8 second pair", 32'(div), 32'h5678);

    // R8 control, ports, then frequency pair
    bus_start();
    put_byte({7'h62, 1'b0}, ack);
    put_byte(cb(1'b0, 3'd1, 2'd2, 1'b0), ack);
    put_byte(8'b1010_1101, ack);
    put_byte(8'h0F, ack); put_byte(8'hF0, ack);
    bus_stop();
    check("R8 div", 32'(div), 32'h0FF0);
    check("R7 oc bit3", 32'(oc), 32'hA);
    check("R7 bs bit3", 32'(bs), 32'h5);
    check("R6 ref", 32'(ref_sel), 2);

    // R6 via general address, ports stay
    bus_start();
    put_byte(8'hC2, ack);
    check("R2 general ack", 32'(ack), 1);
    put_byte(cb(1'b1, 3'd4, 2'd1, 1'b1), ack);
    bus_stop();
    check("R6 general ctrl", 32'({cp_hi, test, ref_sel, tune_off}), 32'({1'b1, 3'd4, 2'd1, 1'b1}));
    check("R7 untouched", 32'({oc, bs}), 32'({4'hA, 3'h5}));

    // R5 first frequency byte then stop
    bus_start();
    put_byte({7'h62, 1'b0}, ack);
    put_byte(8'h7F, ack);
    bus_stop();
    check("R5 div", 32'(div), 32'h0FF0);

    // R11 stop inside second frequency byte
    bus_start();
    put_byte({7'h62, 1'b0}, ack);
    put_byte(8'h33, ack);
    put_bits(8'h99, 5);
    bus_stop();
    check("R11 div", 32'(div), 32'h0FF0);

    // R11 repeated start inside control byte
    bus_start();
    put_byte({7'h62, 1'b0}, ack);
    put_bits(cb(1'b0, 3'd7, 2'd3, 1'b0), 6);
    bus_start();
    bus_stop();
    check("R11 ctrl", 32'({cp_hi, test, ref_sel, tune_off}), 32'({1'b1, 3'd4, 2'd1, 1'b1}));

    // R9 R10 first read: two bytes, power-on flag clears after the first
    lock = 1'b1; adc = 3'd5;
    bus_start();
    put_byte({7'h62, 1'b1}, ack);
    check("R9 read ack", 32'(ack), 1);
    get_byte(1'b1, d);
    check("R10 first status", 32'(d), 32'h80 | 32'h40 | 32'h5);
    get_byte(1'b0, d);
    bus_stop();
    check("R10 second status", 32'(d), 32'h45);

    // R9 sweep of lock and code
    for (int l = 0; l < 2; l++) begin
      for (int a = 0; a < 8; a++) begin
        lock = l[0]; adc = 3'(a);
        bus_start();
        put_byte((l == 1 && a == 7) ? 8'hC3 : {7'h62, 1'b1}, ack);
        check("R9 ack", 32'(ack), 1);
        get_byte(1'b0, d);
        bus_stop();
        check("R9 status", 32'(d), 32'({1'b0, l[0], 3'b000, 3'(a)}));
      end
    end

    check("R12 sda while scl high", 32'(viol), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule